// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Controller

This block holds one pending-interrupt flag for each message buffer of a CAN-style controller. It merges the flags into a single interrupt line. A completion pulse from the protocol engine sets a buffer's flag, whether the buffer sent or received. Software clears flags through a write-one-to-clear port. A per-buffer mask register decides which flags may reach the interrupt output. The flags are read back through a read port that returns them after the mode-dependent remapping.

The low eight flag positions change meaning with the operating mode. A mode state machine has three states:

- `MODE_PLAIN`: every bit is an ordinary buffer flag.
- `MODE_FIFO`: bits 7, 6 and 5 report receive-FIFO overflow, FIFO almost-full warning and frames-available.
- `MODE_FIFO_DMA`: only bit 5 (frames-available) remains. It drives a DMA request instead of an interrupt.

A configuration write moves the machine along named transitions:

- `ENTER_FIFO`: PLAIN→FIFO
- `ENTER_FIFO_DMA`: PLAIN→FIFO_DMA
- `FIFO_TO_DMA`: FIFO→FIFO_DMA
- `DMA_TO_FIFO`: FIFO_DMA→FIFO
- `LEAVE_FIFO`: FIFO→PLAIN or FIFO_DMA→PLAIN

A write that names the current mode is `STAY`. Each transition that changes the mode flushes the low eight flags, so that a stale value cannot be read under a new meaning.

Top module: `mbif_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all flags and all mask bits read 0, the mode is plain, and `irq` and `dma_req` are 0.
- R2: In plain mode, a pulse on `mb_done[i]` sets flag i, visible on `flag_rd` after the next clock edge. Flags from send and receive completions behave alike, and a repeated pulse leaves the flag set.
- R3: A clear write (`clr_we`=1) resets exactly those flags whose `clr_data` bit is 1. Bits written 0 keep their flags unchanged.
- R4: When a set event and a clear of the same bit fall in the same cycle, the flag ends up set.
- R5: `irq` is 1 exactly when some readable flag whose mask bit is 1 is set, apart from the low eight bits in FIFO+DMA mode. A flag with mask bit 0 never raises `irq`.
- R6: In FIFO mode (`cfg_fifo`=1, `cfg_dma`=0), `fifo_ovf_evt` sets bit 7, `fifo_warn_evt` sets bit 6 and `fifo_frm_evt` sets bit 5. Bits 4..0 read 0, and `mb_done[7:0]` has no effect.
- R7: In FIFO+DMA mode (`cfg_fifo`=1, `cfg_dma`=1), only `fifo_frm_evt` sets bit 5. Bits 7, 6 and 4..0 read 0. No flag in bits 7..0 raises `irq`, whatever the mask. Bits 8 and up still raise `irq` as in R5.
- R8: `dma_req` is 1 only in FIFO+DMA mode and exactly while flag 5 is set. A `dma_ack` pulse or a clear write with bit 5 = 1 drops it after one edge, unless a frames-available event falls in the same cycle.
- R9: A configuration write that changes the mode clears flags 7..0 and keeps flags 8 and up. `cfg_fifo`=0 selects plain mode whatever `cfg_dma` is.
- R10: A mask write (`mask_we`=1) replaces the whole mask with `mask_data`, readable on `mask_rd` after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mb_done | input | NUM_MB | Per-buffer successful-transfer pulses |
| fifo_frm_evt | input | 1 | Receive FIFO frames-available event |
| fifo_warn_evt | input | 1 | Receive FIFO almost-full event |
| fifo_ovf_evt | input | 1 | Receive FIFO overflow event |
| dma_ack | input | 1 | DMA acknowledge pulse; clears flag 5 in FIFO+DMA mode |
| clr_we | input | 1 | Flag clear write strobe |
| clr_data | input | NUM_MB | Write-one-to-clear data |
| mask_we | input | 1 | Mask write strobe |
| mask_data | input | NUM_MB | New mask value |
| cfg_we | input | 1 | Mode configuration write strobe |
| cfg_fifo | input | 1 | FIFO mode enable |
| cfg_dma | input | 1 | DMA mode enable |
| flag_rd | output | NUM_MB | Flags after mode remapping |
| mask_rd | output | NUM_MB | Current mask |
| irq | output | 1 | Combined interrupt |
| dma_req | output | 1 | DMA request for FIFO frames |

## Verification
Two functions can fall in the same cycle: setting a flag and clearing it. The set comes from `mb_done` or a FIFO event. The clear comes from a CPU clear write or, in FIFO+DMA mode, from `dma_ack`. The bench drives the event and the clear in the same clock cycle, for a plain buffer bit and for the frames-available bit. One edge later it reads `flag_rd` and `dma_req` and expects the flag still set and the request still raised. A lone clear follows, and the flag must drop.

// File: rtl/mbif_pkg.sv
package mbif_pkg;
    typedef enum logic [1:0] {
        MODE_PLAIN    = 2'd0,
        MODE_FIFO     = 2'd1,
        MODE_FIFO_DMA = 2'd2
    } mbif_mode_e;

    localparam int REMAP_W  = 8;
    localparam int FRM_BIT  = 5;
    localparam int WARN_BIT = 6;
    localparam int OVF_BIT  = 7;
endpackage

// File: rtl/mbif_mode_fsm.sv
module mbif_mode_fsm
    import mbif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_fifo,
    input  logic       cfg_dma,
    output mbif_mode_e mode,
    output logic       flush_lo
);
    mbif_mode_e mode_q;
    mbif_mode_e mode_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_PLAIN;
        else        mode_q <= mode_d;
    end

    // next state
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_PLAIN: begin
                if (cfg_we && cfg_fifo)
                    mode_d = cfg_dma ? MODE_FIFO_DMA : MODE_FIFO;
            end
            MODE_FIFO: begin
                if (cfg_we) begin
                    if (!cfg_fifo)    mode_d = MODE_PLAIN;
                    else if (cfg_dma) mode_d = MODE_FIFO_DMA;
                end
            end
            MODE_FIFO_DMA: begin
                if (cfg_we) begin
                    if (!cfg_fifo)     mode_d = MODE_PLAIN;
                    else if (!cfg_dma) mode_d = MODE_FIFO;
                end
            end
            default: mode_d = MODE_PLAIN;
        endcase
    end

    // outputs
    always_comb begin
        mode     = mode_q;
        flush_lo = cfg_we && (mode_d != mode_q);
    end

    // R9
    leave_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_fifo) |=> (mode == MODE_PLAIN));

    // R7
    enter_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_fifo && cfg_dma) |=> (mode == MODE_FIFO_DMA));
endmodule

// File: rtl/mbif_flag_bank.sv
module mbif_flag_bank #(
    parameter int NUM_MB = 16,
    parameter int LO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_MB-1:0] set_vec,
    input  logic [NUM_MB-1:0] clr_vec,
    input  logic              flush_lo,
    output logic [NUM_MB-1:0] flag_q
);
    for (genvar i = 0; i < NUM_MB; i++) begin : g_bit
        localparam bit IS_LO = (i < LO_W);
        logic flush_here;
        assign flush_here = IS_LO && flush_lo;

        always_ff @(posedge clk) begin
            if (!rst_n)           flag_q[i] <= 1'b0;
            else if (flush_here)  flag_q[i] <= 1'b0;
            else if (set_vec[i])  flag_q[i] <= 1'b1;
            else if (clr_vec[i])  flag_q[i] <= 1'b0;
        end

        // R4
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vec[i] && !flush_here) |=> flag_q[i]);

        // R3
        keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_vec[i] && !flush_here) |=> flag_q[i]);

        // R3
        clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]);
    end
endmodule

// File: rtl/mbif_irq_merge.sv
module mbif_irq_merge
    import mbif_pkg::*;
#(
    parameter int NUM_MB = 16
) (
    input  mbif_mode_e        mode,
    input  logic [NUM_MB-1:0] flag_q,
    input  logic [NUM_MB-1:0] mask_q,
    output logic [NUM_MB-1:0] flag_rd,
    output logic              irq,
    output logic              dma_req
);
    localparam int HI_W = NUM_MB - REMAP_W;

    logic [REMAP_W-1:0] lo_valid;
    logic [REMAP_W-1:0] lo_elig;

    always_comb begin
        lo_valid = '0;
        lo_elig  = '0;
        unique case (mode)
            MODE_PLAIN: begin
                lo_valid = '1;
                lo_elig  = '1;
            end
            MODE_FIFO: begin
                lo_valid[FRM_BIT]  = 1'b1;
                lo_valid[WARN_BIT] = 1'b1;
                lo_valid[OVF_BIT]  = 1'b1;
                lo_elig            = lo_valid;
            end
            MODE_FIFO_DMA: begin
                lo_valid[FRM_BIT] = 1'b1;
            end
            default: begin
                lo_valid = '0;
                lo_elig  = '0;
            end
        endcase
    end

    always_comb begin
        flag_rd = flag_q & {{HI_W{1'b1}}, lo_valid};
        irq     = |(flag_q & mask_q & {{HI_W{1'b1}}, lo_elig});
        dma_req = (mode == MODE_FIFO_DMA) && flag_q[FRM_BIT];
    end
endmodule

// File: rtl/mbif_irq_ctrl.sv
module mbif_irq_ctrl
    import mbif_pkg::*;
#(
    parameter int NUM_MB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_MB-1:0] mb_done,
    input  logic              fifo_frm_evt,
    input  logic              fifo_warn_evt,
    input  logic              fifo_ovf_evt,
    input  logic              dma_ack,
    input  logic              clr_we,
    input  logic [NUM_MB-1:0] clr_data,
    input  logic              mask_we,
    input  logic [NUM_MB-1:0] mask_data,
    input  logic              cfg_we,
    input  logic              cfg_fifo,
    input  logic              cfg_dma,
    output logic [NUM_MB-1:0] flag_rd,
    output logic [NUM_MB-1:0] mask_rd,
    output logic              irq,
    output logic              dma_req
);
    mbif_mode_e        mode;
    logic              flush_lo;
    logic [NUM_MB-1:0] set_vec;
    logic [NUM_MB-1:0] clr_vec;
    logic [NUM_MB-1:0] flag_q;
    logic [NUM_MB-1:0] mask_q;

    mbif_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_fifo (cfg_fifo),
        .cfg_dma  (cfg_dma),
        .mode     (mode),
        .flush_lo (flush_lo)
    );

    // event sources per mode
    always_comb begin
        set_vec = mb_done;
        unique case (mode)
            MODE_PLAIN: ;
            MODE_FIFO: begin
                set_vec[REMAP_W-1:0] = '0;
                set_vec[FRM_BIT]     = fifo_frm_evt;
                set_vec[WARN_BIT]    = fifo_warn_evt;
                set_vec[OVF_BIT]     = fifo_ovf_evt;
            end
            MODE_FIFO_DMA: begin
                set_vec[REMAP_W-1:0] = '0;
                set_vec[FRM_BIT]     = fifo_frm_evt;
            end
            default: set_vec = '0;
        endcase
    end

    always_comb begin
        clr_vec = clr_we ? clr_data : '0;
        if (mode == MODE_FIFO_DMA && dma_ack)
            clr_vec[FRM_BIT] = 1'b1;
    end

    mbif_flag_bank #(.NUM_MB(NUM_MB), .LO_W(REMAP_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .flush_lo (flush_lo),
        .flag_q   (flag_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_data;
    end
    assign mask_rd = mask_q;

    mbif_irq_merge #(.NUM_MB(NUM_MB)) u_merge (
        .mode    (mode),
        .flag_q  (flag_q),
        .mask_q  (mask_q),
        .flag_rd (flag_rd),
        .irq     (irq),
        .dma_req (dma_req)
    );

    logic hi_pend;
    assign hi_pend = |((flag_rd & mask_q) >> REMAP_W);

    // R8
    dma_mode_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (mode == MODE_FIFO_DMA));

    // R7
    no_fifo_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FIFO_DMA && !hi_pend) |-> !irq);

    // R6
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_PLAIN) |-> (flag_rd[4:0] == 5'd0));

    // R5
    masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_rd & mask_q) == '0) |-> !irq);

    // R10
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_rd == $past(mask_data)));
endmodule

// File: tb/test_mbif_irq_ctrl.sv
module test_mbif_irq_ctrl;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] mb_done = '0;
    logic         fifo_frm_evt = 1'b0, fifo_warn_evt = 1'b0, fifo_ovf_evt = 1'b0;
    logic         dma_ack = 1'b0;
    logic         clr_we = 1'b0;
    logic [N-1:0] clr_data = '0;
    logic         mask_we = 1'b0;
    logic [N-1:0] mask_data = '0;
    logic         cfg_we = 1'b0, cfg_fifo = 1'b0, cfg_dma = 1'b0;
    logic [N-1:0] flag_rd, mask_rd;
    logic         irq, dma_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mbif_irq_ctrl #(.NUM_MB(N)) i_mbif_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .mb_done(mb_done),
        .fifo_frm_evt(fifo_frm_evt), .fifo_warn_evt(fifo_warn_evt),
        .fifo_ovf_evt(fifo_ovf_evt), .dma_ack(dma_ack),
        .clr_we(clr_we), .clr_data(clr_data),
        .mask_we(mask_we), .mask_data(mask_data),
        .cfg_we(cfg_we), .cfg_fifo(cfg_fifo), .cfg_dma(cfg_dma),
        .flag_rd(flag_rd), .mask_rd(mask_rd), .irq(irq), .dma_req(dma_req)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        mb_done = '0; fifo_frm_evt = 0; fifo_warn_evt = 0; fifo_ovf_evt = 0;
        dma_ack = 0; clr_we = 0; clr_data = '0; mask_we = 0; cfg_we = 0;
    endtask

    task automatic pulse_done(input logic [N-1:0] v);
        @(negedge clk); mb_done = v; @(negedge clk); idle();
    endtask

    task automatic cpu_clear(input logic [N-1:0] v);
        @(negedge clk); clr_we = 1; clr_data = v; @(negedge clk); idle();
    endtask

    task automatic write_mask(input logic [N-1:0] v);
        @(negedge clk); mask_we = 1; mask_data = v; @(negedge clk); idle();
    endtask

    task automatic write_cfg(input logic f, input logic d);
        @(negedge clk); cfg_we = 1; cfg_fifo = f; cfg_dma = d; @(negedge clk); idle();
    endtask

    task automatic pulse_fifo(input logic frm, input logic warn, input logic ovf);
        @(negedge clk); fifo_frm_evt = frm; fifo_warn_evt = warn; fifo_ovf_evt = ovf;
        @(negedge clk); idle();
    endtask

    task automatic t_reset();
        check("R1 flags", flag_rd, '0);
        check("R1 mask", mask_rd, '0);
        check("R1 irq", N'(irq), '0);
        check("R1 dma_req", N'(dma_req), '0);
    endtask

    task automatic t_set();
        pulse_done(16'h0201);                 // bit0 tx, bit9 rx
        check("R2 set", flag_rd, 16'h0201);
        pulse_done(16'h0201);
        check("R2 repeat", flag_rd, 16'h0201);
    endtask

    task automatic t_clear();
        cpu_clear(16'h0001);
        check("R3 w1c", flag_rd, 16'h0200);
        cpu_clear(16'h0000);
        check("R3 write zero", flag_rd, 16'h0200);
        cpu_clear(16'h0200);
        check("R3 clear rest", flag_rd, 16'h0000);
    endtask

    task automatic t_race();
        pulse_done(16'h0008);
        @(negedge clk); mb_done = 16'h0008; clr_we = 1; clr_data = 16'h0008;
        @(negedge clk); idle();
        check("R4 set wins", flag_rd, 16'h0008);
        cpu_clear(16'h0008);
        check("R4 later clear", flag_rd, 16'h0000);
    endtask

    task automatic t_mask();
        pulse_done(16'h0010);
        check("R5 no mask", N'(irq), '0);
        write_mask(16'h0100);
        check("R10 mask read", mask_rd, 16'h0100);
        check("R5 other mask", N'(irq), '0);
        write_mask(16'h0010);
        check("R5 masked on", N'(irq), 1);
        cpu_clear(16'h0010);
        check("R5 after clear", N'(irq), '0);
    endtask

    task automatic t_fifo();
        pulse_done(16'h0204);
        write_cfg(1, 0);
        check("R9 flush low", flag_rd, 16'h0200);
        pulse_done(16'h00FF);
        check("R6 mb low ignored", flag_rd, 16'h0200);
        pulse_fifo(1, 0, 0);
        check("R6 frames bit5", flag_rd, 16'h0220);
        pulse_fifo(0, 1, 0);
        check("R6 warn bit6", flag_rd, 16'h0260);
        pulse_fifo(0, 0, 1);
        check("R6 ovf bit7", flag_rd, 16'h02E0);
        cpu_clear(16'h0200);
        write_mask(16'h0080);
        check("R6 ovf irq", N'(irq), 1);
        check("R8 no dma in fifo", N'(dma_req), '0);
    endtask

    task automatic t_dma();
        write_cfg(1, 1);
        check("R9 flush on dma", flag_rd, 16'h0000);
        pulse_fifo(0, 1, 1);
        check("R7 warn ovf unused", flag_rd, 16'h0000);
        write_mask(16'hFFFF);
        pulse_fifo(1, 0, 0);
        check("R7 frames bit5", flag_rd, 16'h0020);
        check("R8 dma_req", N'(dma_req), 1);
        check("R7 no fifo irq", N'(irq), '0);
        @(negedge clk); dma_ack = 1; @(negedge clk); idle();
        check("R8 ack clears", N'(dma_req), '0);
        pulse_fifo(1, 0, 0);
        cpu_clear(16'h0020);
        check("R8 cpu clears", N'(dma_req), '0);
        @(negedge clk); fifo_frm_evt = 1; dma_ack = 1; @(negedge clk); idle();
        check("R8 set wins over ack", N'(dma_req), 1);
        pulse_done(16'h1000);
        check("R7 high bit irq", N'(irq), 1);
        check("R7 high bit read", flag_rd, 16'h1020);
    endtask

    task automatic t_dma_no_fifo();
        write_cfg(0, 1);
        check("R9 plain keeps high", flag_rd, 16'h1000);
        pulse_done(16'h0004);
        check("R9 plain mode", flag_rd, 16'h1004);
        check("R9 no dma_req", N'(dma_req), '0);
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set();
        t_clear();
        t_race();
        t_mask();
        t_fifo();
        t_dma();
        t_dma_no_fifo();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule